// File: doc/BRIEF.md
# Character LCD Nibble-Mode Writer

This block brings up a two-line character display over a 4-bit data bus and fills both lines with fixed text, with no help from software. After reset it walks a constant start-up command list, writes forty characters to the first line, moves the display RAM address to the start of the second line, and writes forty more characters there. Every byte is split into an upper nibble followed by a lower nibble, because only the upper four data lanes of the display are wired.

The display is much slower than the system clock. The block therefore divides the system clock down to a slow enable strobe. A new nibble and register-select value are presented on the same system clock edge on which the strobe rises. They then stay constant through the whole high phase and through the falling edge, where the display latches them. After the last nibble the strobe finishes its normal high time, falls, and stays low until the next reset. The outputs keep their last values.

The reset input is asynchronous and active low. Inside the block it is released through a two-flop synchroniser.

Top module: `lcd_nibble_writer`

## Requirements
- R1: While reset is asserted, lcd_en, lcd_rs and lcd_data are all 0. After reset is released, the first rising edge of lcd_en occurs on the (DIV_TERM+3)-th rising clock edge, counting two edges for the reset synchroniser and DIV_TERM+1 edges for the divider.
- R2: Each strobe is high for DIV_TERM+1 clock cycles. Between strobes it is low for DIV_TERM+1 cycles. lcd_data and lcd_rs change only on the clock edge where lcd_en rises.
- R3: The first 16 strobes carry the start-up nibbles with lcd_rs = 0, in this order: 3,3,3,2, 2,8, 0,C, 0,6, 0,1, 0,2, 8,0. These are the 4-bit mode entry followed by the commands 28h, 0Ch, 06h, 01h, 02h and 80h.
- R4: The next 80 strobes carry first-line characters with lcd_rs = 1. Character i (0 to 39) is 41h+i. Its upper nibble is sent first, then its lower nibble.
- R5: The next 2 strobes carry the second-line address command C0h with lcd_rs = 0: nibble C, then nibble 0.
- R6: The next 80 strobes carry second-line characters with lcd_rs = 1. Character i (0 to 39) is 30h+i, upper nibble first.
- R7: After the 178th strobe, lcd_en falls after its normal high time and then stays low. lcd_rs and lcd_data keep the last values (1 and 7h).
- R8: Asserting reset at any point clears all outputs at once, without waiting for a clock edge. After release the sequence restarts from the first start-up nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcd_rs | output | 1 | Register select: 0 for commands, 1 for character data |
| lcd_en | output | 1 | Enable strobe; the display latches on its falling edge |
| lcd_data | output | 4 | Nibble bus to the upper data lanes of the display |

## Verification
Two events share a single clock edge: the divider raising the strobe, and the sequencer advancing its table pointer and presenting a new nibble. At a phase boundary, that same edge also wraps the shared index and switches tables. The bench provokes every boundary by running the complete 178-strobe stream. For each strobe it checks the nibble against a table the bench computes itself, and it checks that the bus holds steady across the whole high window, including the strobes that straddle the start-up/line-one, line-one/address, address/line-two and line-two/idle boundaries. Seeded random mid-stream resets then confirm that an asynchronous reset landing on any table position restarts the stream cleanly at the first start-up nibble.

// File: rtl/lcd_nw_pkg.sv
package lcd_nw_pkg;

  localparam int INSTR_LEN  = 16;
  localparam int LINE_LEN   = 40;
  localparam int WORD_W     = 10;
  localparam logic [7:0] LINE1_BASE = 8'h41;
  localparam logic [7:0] LINE2_BASE = 8'h30;
  localparam logic [7:0] ADDR_CMD   = 8'hC0;

  typedef enum logic [2:0] {
    PH_INSTR,
    PH_L1_HI,
    PH_L1_LO,
    PH_ADR_HI,
    PH_ADR_LO,
    PH_L2_HI,
    PH_L2_LO,
    PH_IDLE
  } phase_e;

  // Start-up word: {rs, rw, byte}; only byte[7:4] reaches the 4-bit bus.
  function automatic logic [WORD_W-1:0] instr_word(input logic [3:0] i);
    logic [3:0] nib;
    case (i)
      4'd0, 4'd1, 4'd2: nib = 4'h3;
      4'd3, 4'd4:       nib = 4'h2;
      4'd5:             nib = 4'h8;
      4'd7:             nib = 4'hC;
      4'd9:             nib = 4'h6;
      4'd11:            nib = 4'h1;
      4'd13:            nib = 4'h2;
      4'd14:            nib = 4'h8;
      default:          nib = 4'h0;
    endcase
    return {1'b0, 1'b0, nib, 4'h0};
  endfunction

  function automatic logic [7:0] line_char(input logic second, input logic [7:0] idx);
    return (second ? LINE2_BASE : LINE1_BASE) + idx;
  endfunction

endpackage

// File: rtl/lcd_nw_divider.sv
module lcd_nw_divider #(
  parameter int DIV_W    = 23,
  parameter int DIV_TERM = 124_999
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_low,
  output logic en_o,
  output logic step_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             en_q, en_d;
  logic             wrap;

  assign wrap   = (cnt_q == DIV_W'(DIV_TERM));
  assign step_o = wrap && !en_q && !hold_low;
  assign en_o   = en_q;

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    en_d  = en_q;
    if (wrap) begin
      if (en_q)           en_d = 1'b0;
      else if (!hold_low) en_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= en_d;
    end
  end

  // R2: the divider count never passes its terminal value
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DIV_W'(DIV_TERM));

  // R1: an advance request is always followed by a high strobe
  a_r1_step_raises_en: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> en_q);

endmodule

// File: rtl/lcd_nw_sequencer.sv
module lcd_nw_sequencer
  import lcd_nw_pkg::*;
#(
  parameter int N_INSTR = INSTR_LEN,
  parameter int N_LINE  = LINE_LEN
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_i,
  output logic       rs_o,
  output logic [3:0] nib_o,
  output logic       done_o
);

  localparam int IDX_W = $clog2(N_LINE > N_INSTR ? N_LINE : N_INSTR);

  phase_e             phase_q, phase_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               rs_q, rs_d;
  logic [3:0]         nib_q, nib_d;
  logic [WORD_W-1:0]  iword;
  logic [7:0]         ch1, ch2;
  logic               last_instr, last_char;

  assign iword      = instr_word(4'(idx_q));
  assign ch1        = line_char(1'b0, 8'(idx_q));
  assign ch2        = line_char(1'b1, 8'(idx_q));
  assign last_instr = (idx_q == IDX_W'(N_INSTR - 1));
  assign last_char  = (idx_q == IDX_W'(N_LINE - 1));

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    rs_d    = rs_q;
    nib_d   = nib_q;
    if (step_i) begin
      case (phase_q)
        PH_INSTR: begin
          rs_d  = iword[WORD_W-1];
          nib_d = iword[7:4];
          if (last_instr) begin
            phase_d = PH_L1_HI;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        PH_L1_HI: begin
          rs_d    = 1'b1;
          nib_d   = ch1[7:4];
          phase_d = PH_L1_LO;
        end
        PH_L1_LO: begin
          nib_d = ch1[3:0];
          if (last_char) begin
            phase_d = PH_ADR_HI;
            idx_d   = '0;
          end else begin
            phase_d = PH_L1_HI;
            idx_d   = idx_q + 1'b1;
          end
        end
        PH_ADR_HI: begin
          rs_d    = 1'b0;
          nib_d   = ADDR_CMD[7:4];
          phase_d = PH_ADR_LO;
        end
        PH_ADR_LO: begin
          nib_d   = ADDR_CMD[3:0];
          phase_d = PH_L2_HI;
        end
        PH_L2_HI: begin
          rs_d    = 1'b1;
          nib_d   = ch2[7:4];
          phase_d = PH_L2_LO;
        end
        PH_L2_LO: begin
          nib_d = ch2[3:0];
          if (last_char) begin
            phase_d = PH_IDLE;
            idx_d   = '0;
          end else begin
            phase_d = PH_L2_HI;
            idx_d   = idx_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_INSTR;
      idx_q   <= '0;
      rs_q    <= 1'b0;
      nib_q   <= 4'h0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      rs_q    <= rs_d;
      nib_q   <= nib_d;
    end
  end

  assign rs_o   = rs_q;
  assign nib_o  = nib_q;
  assign done_o = (phase_q == PH_IDLE);

  // R3: the shared index stays inside the longest table
  a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < IDX_W'(N_LINE));

  // R4: waiting for a lower nibble means an upper character nibble is on the bus
  a_r4_lo_phase_rs: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_L1_LO || phase_q == PH_L2_LO) |-> rs_q);

  // R5: between the two address nibbles the bus shows the command's upper nibble
  a_r5_addr_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ADR_LO) |-> (!rs_q && nib_q == ADDR_CMD[7:4]));

endmodule

// File: rtl/lcd_nibble_writer.sv
module lcd_nibble_writer #(
  parameter int DIV_W    = 23,
  parameter int DIV_TERM = 124_999
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       lcd_rs,
  output logic       lcd_en,
  output logic [3:0] lcd_data
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       step, done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  lcd_nw_divider #(
    .DIV_W    (DIV_W),
    .DIV_TERM (DIV_TERM)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .hold_low (done),
    .en_o     (lcd_en),
    .step_o   (step)
  );

  lcd_nw_sequencer u_seq (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .step_i (step),
    .rs_o   (lcd_rs),
    .nib_o  (lcd_data),
    .done_o (done)
  );

  // R2: the bus moves only together with a rising strobe
  a_r2_bus_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!$stable(lcd_data) || !$stable(lcd_rs)) |-> $rose(lcd_en));

  // R7: once finished and low, the strobe never rises again
  a_r7_idle_stays_low: assert property (@(posedge clk) disable iff (!rst_core_n)
    (done && !lcd_en) |=> !lcd_en);

endmodule

// File: tb/lcd_nibble_writer_bench.sv
`timescale 1ns/1ps
module lcd_nibble_writer_bench;

  localparam int TERM  = 3;
  localparam int TOTAL = 178;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lcd_rs, lcd_en;
  logic [3:0] lcd_data;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  lcd_nibble_writer #(.DIV_W(23), .DIV_TERM(TERM)) u_lcd_nibble_writer (
    .clk(clk), .rst_n(rst_n), .lcd_rs(lcd_rs), .lcd_en(lcd_en), .lcd_data(lcd_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int start_nib(input int i);
    int t[16] = '{3,3,3,2, 2,8, 0,12, 0,6, 0,1, 0,2, 8,0};
    return t[i];
  endfunction

  // expected {rs, nibble} of strobe k
  function automatic int exp_strobe(input int k);
    int j, ch;
    if (k < 16) return start_nib(k);
    if (k < 96) begin
      j = k - 16; ch = 'h41 + j / 2;
      return 16 | ((j % 2 == 0) ? (ch >> 4) : (ch & 15));
    end
    if (k == 96) return 12;
    if (k == 97) return 0;
    j = k - 98; ch = 'h30 + j / 2;
    return 16 | ((j % 2 == 0) ? (ch >> 4) : (ch & 15));
  endfunction

  function automatic string req_of(input int k);
    if (k < 16) return "R3";
    if (k < 96) return "R4";
    if (k < 98) return "R5";
    return "R6";
  endfunction

  task automatic get_strobe(output int val, output int lo, output int hi, output bit stable);
    lo = 0; hi = 0; stable = 1'b1;
    @(negedge clk);
    while (!lcd_en && lo < 64) begin lo++; @(negedge clk); end
    val = {lcd_rs, lcd_data};
    hi = 1;
    @(negedge clk);
    while (lcd_en && hi < 64) begin
      if ({lcd_rs, lcd_data} != val[4:0]) stable = 1'b0;
      hi++;
      @(negedge clk);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!lcd_en && !lcd_rs && lcd_data == 4'h0, "R1", "outputs in reset",
          {lcd_en, lcd_rs, lcd_data}, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_strobes(input int count, input bit timing);
    int v, lo, hi;
    bit st;
    for (int k = 0; k < count; k++) begin
      get_strobe(v, lo, hi, st);
      check(v == exp_strobe(k), req_of(k), $sformatf("strobe %0d value", k), v, exp_strobe(k));
      if (timing) begin
        if (k == 0)
          check(lo == TERM + 2, "R1", "cycles to first strobe", lo, TERM + 2);
        else
          check(lo == TERM, "R2", "strobe low time", lo, TERM);
        check(hi == TERM + 1, "R2", "strobe high time", hi, TERM + 1);
        check(st, "R2", $sformatf("bus stable in strobe %0d", k), 0, 1);
      end
    end
  endtask

  initial begin
    int r;
    bit idle_ok;
    void'($urandom(32'h5EED_1602));

    // full stream with timing and boundary checks
    apply_reset();
    run_strobes(TOTAL, 1'b1);

    // R7: idle hold after the last nibble
    idle_ok = 1'b1;
    repeat (8 * (TERM + 1)) begin
      @(negedge clk);
      if (lcd_en || !lcd_rs || lcd_data != 4'h7) idle_ok = 1'b0;
    end
    check(idle_ok, "R7", "idle hold en low, rs 1, data 7", {lcd_en, lcd_rs, lcd_data}, 'h7 | 'h10);

    // R8: seeded random mid-stream resets, plus a directed one at a boundary
    for (int t = 0; t < 3; t++) begin
      r = (t == 0) ? 96 : int'($urandom_range(20, 170));
      apply_reset();
      run_strobes(r, 1'b0);
      #0.5 rst_n = 1'b0;
      #0.5;
      check(!lcd_en && !lcd_rs && lcd_data == 4'h0, "R8",
            $sformatf("async clear after %0d strobes", r), {lcd_en, lcd_rs, lcd_data}, 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      run_strobes(20, 1'b1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule